// File: doc/BRIEF.md
# Receive Error-Bit Response Policy

This block sits behind the bit-level receiver of a consumer-electronics control bus. The receiver raises one-cycle strobes when it sees one of three line faults: a rising edge at the wrong time, a bit period that is too short, or a bit period that is too long. For each strobe the block decides two things. The first is whether the current reception is abandoned. The second is whether an error bit is driven onto the shared bus.

An error bit is a low pulse on the open-drain output. It lasts three half nominal bit periods, counted on a half-bit tick supplied from outside. Whether a fault produces an error bit depends on four policy bits, on whether the frame in progress is a broadcast, and on whether the device listens to all traffic. For broadcast frames a dedicated control overrides the per-fault enables. Every fault also sets a sticky status flag, which is cleared by writing 1 to it.

Top module: `cec_errbit_policy`

## Requirements
- R1: After reset the line pull output, the abort pulse and all three status flags are 0.
- R2: A rising-edge fault raises `rx_abort` for one cycle, on the cycle after the strobe, only when `pol_abort_on_rise` is 1. Short and long period faults always raise `rx_abort` on the cycle after the strobe.
- R3: In a directed (non-broadcast) frame, a rising-edge fault drives an error bit only when both `pol_abort_on_rise` and `pol_bit_on_rise` are 1.
- R4: In a directed frame, a long period fault drives an error bit exactly when `pol_bit_on_long` is 1.
- R5: In a directed frame, a short period fault always drives an error bit.
- R6: In a broadcast frame with `pol_bcast_quiet` = 0, a rising-edge fault drives an error bit whenever `pol_abort_on_rise` is 1, regardless of `pol_bit_on_rise`. A long period fault drives one regardless of `pol_bit_on_long`.
- R7: In a broadcast frame with `pol_bcast_quiet` = 1, no fault drives an error bit.
- R8: In a broadcast frame, a short period fault drives no error bit while `listen_all` is 1. With `listen_all` = 0 and `pol_bcast_quiet` = 0 it drives one.
- R9: `line_pull` rises on the cycle after a qualifying strobe. It stays 1 until the third `half_bit_tick` after that strobe, and drops on the cycle after that tick.
- R10: A fault arriving while an error bit is being driven neither restarts nor lengthens the pulse.
- R11: `err_flags` bit 0 is the rising-edge fault, bit 1 the short period fault, and bit 2 the long period fault. A flag is set on the cycle after its strobe, whatever the policy. Writing 1 to the same bit of `flag_clr` clears it, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_bit_tick | input | 1 | One-cycle pulse every half nominal bit period |
| fault_rise | input | 1 | Rising-edge fault strobe |
| fault_short | input | 1 | Short bit period fault strobe |
| fault_long | input | 1 | Long bit period fault strobe |
| frame_bcast | input | 1 | Frame in progress is a broadcast |
| listen_all | input | 1 | Device receives all traffic, not only its own |
| pol_abort_on_rise | input | 1 | A rising-edge fault abandons reception |
| pol_bit_on_rise | input | 1 | Error bit enable for rising-edge faults |
| pol_bit_on_long | input | 1 | Error bit enable for long period faults |
| pol_bcast_quiet | input | 1 | Suppress all error bits in broadcast frames |
| flag_clr | input | 3 | Write-1-to-clear for the status flags |
| rx_abort | output | 1 | One-cycle pulse: reception abandoned |
| line_pull | output | 1 | Open-drain enable: 1 pulls the bus low |
| err_flags | output | 3 | Sticky fault flags |

## Verification
Each fault type is applied alone, in directed and in broadcast frames, across the policy settings that flip the outcome. This separates a rising-edge fault gated by the abort bit from one gated by its enable, and the broadcast override from the per-fault enables. The short period fault is applied with the listen-all mode both on and off to isolate the broadcast exception. Pulse timing is probed between half-bit ticks and with a second fault injected mid-pulse, which tells a counted pulse from a restarted one. Flag clearing is tried alone and in the same cycle as a new strobe.

// File: rtl/cec_errpol_pkg.sv
package cec_errpol_pkg;

    localparam int N_KINDS = 3;

    typedef enum logic [1:0] {
        K_RISE  = 2'd0,
        K_SHORT = 2'd1,
        K_LONG  = 2'd2
    } fault_kind_e;

    typedef struct packed {
        logic abort_on_rise;
        logic bit_on_rise;
        logic bit_on_long;
        logic bcast_quiet;
    } pol_cfg_t;

    // Does a fault of this kind abandon the reception?
    function automatic logic fault_aborts(pol_cfg_t c, fault_kind_e k);
        case (k)
            K_RISE:  return c.abort_on_rise;
            default: return 1'b1;
        endcase
    endfunction

    // Does a fault of this kind call for an error bit on the line?
    function automatic logic fault_wants_bit(pol_cfg_t c, logic bcast, logic lst, fault_kind_e k);
        logic r;
        r = 1'b0;
        if (bcast) begin
            if (!c.bcast_quiet) begin
                case (k)
                    K_RISE:  r = c.abort_on_rise;
                    K_SHORT: r = !lst;
                    default: r = 1'b1;
                endcase
            end
        end else begin
            case (k)
                K_RISE:  r = c.abort_on_rise & c.bit_on_rise;
                K_SHORT: r = 1'b1;
                default: r = c.bit_on_long;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/cec_errpol_decide.sv
module cec_errpol_decide
    import cec_errpol_pkg::*;
#(
    parameter int KINDS = N_KINDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KINDS-1:0] fault,
    input  pol_cfg_t         cfg,
    input  logic             bcast,
    input  logic             lst,
    output logic             start_bit,
    output logic             abort_q
);
    logic [KINDS-1:0] want;
    logic [KINDS-1:0] stop;

    for (genvar i = 0; i < KINDS; i++) begin : g_kind
        assign want[i] = fault[i] & fault_wants_bit(cfg, bcast, lst, fault_kind_e'(i));
        assign stop[i] = fault[i] & fault_aborts(cfg, fault_kind_e'(i));
    end

    assign start_bit = |want;

    always_ff @(posedge clk) begin
        if (rst) abort_q <= 1'b0;
        else     abort_q <= |stop;
    end

    // R2: a long period fault always abandons reception on the next cycle
    a_r2_long_aborts: assert property (@(posedge clk) disable iff (rst)
        fault[K_LONG] |=> abort_q);
    // R7: quiet broadcast never asks for an error bit
    a_r7_bcast_quiet: assert property (@(posedge clk) disable iff (rst)
        (bcast && cfg.bcast_quiet) |-> !start_bit);
endmodule

// File: rtl/cec_errpol_pulse.sv
module cec_errpol_pulse #(
    parameter int HALVES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic pull
);
    localparam int CW = $clog2(HALVES + 1);
    localparam logic [CW-1:0] LAST = CW'(HALVES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pull <= 1'b0;
            cnt  <= '0;
        end else if (!pull) begin
            if (start) begin
                pull <= 1'b1;
                cnt  <= '0;
            end
        end else if (tick) begin
            if (cnt == LAST) begin
                pull <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R9: the pulse only begins in response to a start request
    a_r9_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(pull) |-> $past(start));
    // R10: without a tick the pulse cannot end, whatever arrives meanwhile
    a_r10_no_early_end: assert property (@(posedge clk) disable iff (rst)
        (pull && !tick) |=> pull);
    // R9: the half-period count never passes its limit
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/cec_errpol_flags.sv
module cec_errpol_flags #(
    parameter int KINDS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KINDS-1:0] set,
    input  logic [KINDS-1:0] clr,
    output logic [KINDS-1:0] flags
);
    for (genvar i = 0; i < KINDS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end

    // R11: a strobe always leaves its flag set on the next cycle
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        set[0] |=> flags[0]);
    // R11: a flag without strobe or clear holds its value
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (set[1] == 1'b0 && clr[1] == 1'b0) |=> $stable(flags[1]));
endmodule

// File: rtl/cec_errbit_policy.sv
module cec_errbit_policy
    import cec_errpol_pkg::*;
#(
    parameter int ERR_HALVES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       half_bit_tick,
    input  logic       fault_rise,
    input  logic       fault_short,
    input  logic       fault_long,
    input  logic       frame_bcast,
    input  logic       listen_all,
    input  logic       pol_abort_on_rise,
    input  logic       pol_bit_on_rise,
    input  logic       pol_bit_on_long,
    input  logic       pol_bcast_quiet,
    input  logic [2:0] flag_clr,
    output logic       rx_abort,
    output logic       line_pull,
    output logic [2:0] err_flags
);
    pol_cfg_t             cfg;
    logic [N_KINDS-1:0]   fault_vec;
    logic                 start_bit;

    assign cfg = '{abort_on_rise: pol_abort_on_rise, bit_on_rise: pol_bit_on_rise,
                   bit_on_long: pol_bit_on_long, bcast_quiet: pol_bcast_quiet};
    assign fault_vec = {fault_long, fault_short, fault_rise};

    cec_errpol_decide #(.KINDS(N_KINDS)) u_decide (
        .clk(clk), .rst(rst), .fault(fault_vec), .cfg(cfg),
        .bcast(frame_bcast), .lst(listen_all),
        .start_bit(start_bit), .abort_q(rx_abort)
    );

    cec_errpol_pulse #(.HALVES(ERR_HALVES)) u_pulse (
        .clk(clk), .rst(rst), .start(start_bit), .tick(half_bit_tick), .pull(line_pull)
    );

    cec_errpol_flags #(.KINDS(N_KINDS)) u_flags (
        .clk(clk), .rst(rst), .set(fault_vec), .clr(flag_clr), .flags(err_flags)
    );

    // R7: with quiet broadcast and an idle line, no fault starts a pulse
    a_r7_line_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!line_pull && frame_bcast && pol_bcast_quiet) |=> !line_pull);
    // R2: a rising-edge fault with abort disabled never aborts alone
    a_r2_rise_no_abort: assert property (@(posedge clk) disable iff (rst)
        (fault_rise && !fault_short && !fault_long && !pol_abort_on_rise) |=> !rx_abort);
endmodule

// File: tb/tb_cec_errbit_policy.sv
module tb_cec_errbit_policy;
    logic clk = 1'b0;
    logic rst;
    logic half_bit_tick, fault_rise, fault_short, fault_long;
    logic frame_bcast, listen_all;
    logic pol_abort_on_rise, pol_bit_on_rise, pol_bit_on_long, pol_bcast_quiet;
    logic [2:0] flag_clr;
    logic rx_abort, line_pull;
    logic [2:0] err_flags;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    cec_errbit_policy dut (
        .clk(clk), .rst(rst), .half_bit_tick(half_bit_tick),
        .fault_rise(fault_rise), .fault_short(fault_short), .fault_long(fault_long),
        .frame_bcast(frame_bcast), .listen_all(listen_all),
        .pol_abort_on_rise(pol_abort_on_rise), .pol_bit_on_rise(pol_bit_on_rise),
        .pol_bit_on_long(pol_bit_on_long), .pol_bcast_quiet(pol_bcast_quiet),
        .flag_clr(flag_clr), .rx_abort(rx_abort), .line_pull(line_pull),
        .err_flags(err_flags)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // cfg = {abort_on_rise, bit_on_rise, bit_on_long, bcast_quiet}
    task automatic set_cfg(logic [3:0] c);
        {pol_abort_on_rise, pol_bit_on_rise, pol_bit_on_long, pol_bcast_quiet} = c;
    endtask

    task automatic tick_once();
        @(negedge clk) half_bit_tick = 1'b1;
        @(negedge clk) half_bit_tick = 1'b0;
    endtask

    task automatic strike(logic [2:0] v);
        @(negedge clk) {fault_long, fault_short, fault_rise} = v;
        @(negedge clk) {fault_long, fault_short, fault_rise} = 3'b000;
    endtask

    task automatic settle();
        @(negedge clk) flag_clr = 3'b111;
        @(negedge clk) flag_clr = 3'b000;
        tick_once(); tick_once(); tick_once();
    endtask

    // One fault, one policy: check error bit, abort and flag on the next cycle.
    task automatic case_one(string req, logic [2:0] v, logic bc, logic lst,
                            logic [3:0] c, logic exp_bit, logic exp_abort);
        settle();
        frame_bcast = bc; listen_all = lst; set_cfg(c);
        strike(v);
        check({req, " line_pull"}, 32'(line_pull), 32'(exp_bit));
        check({req, " rx_abort"}, 32'(rx_abort), 32'(exp_abort));
        check({req, " flags"}, 32'(err_flags), 32'(v));
        settle();
        check({req, " pulse over"}, 32'(line_pull), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 line_pull", 32'(line_pull), 32'd0);
        check("R1 rx_abort", 32'(rx_abort), 32'd0);
        check("R1 flags", 32'(err_flags), 32'd0);
    endtask

    task automatic t_directed();
        case_one("R2 R3 rise abort+en", 3'b001, 0, 0, 4'b1100, 1, 1);
        case_one("R3 rise en no abort", 3'b001, 0, 0, 4'b0100, 0, 0);
        case_one("R3 rise abort no en", 3'b001, 0, 0, 4'b1000, 0, 1);
        case_one("R4 long en", 3'b100, 0, 0, 4'b0010, 1, 1);
        case_one("R4 long no en", 3'b100, 0, 0, 4'b0000, 0, 1);
        case_one("R5 short directed", 3'b010, 0, 1, 4'b0000, 1, 1);
    endtask

    task automatic t_broadcast();
        case_one("R6 bc rise abort", 3'b001, 1, 0, 4'b1000, 1, 1);
        case_one("R6 bc rise no abort", 3'b001, 1, 0, 4'b0100, 0, 0);
        case_one("R6 bc long no en", 3'b100, 1, 0, 4'b0000, 1, 1);
        case_one("R7 bc quiet rise", 3'b001, 1, 0, 4'b1101, 0, 1);
        case_one("R7 bc quiet long", 3'b100, 1, 0, 4'b0011, 0, 1);
        case_one("R7 bc quiet short", 3'b010, 1, 0, 4'b0001, 0, 1);
        case_one("R8 bc short listen_all", 3'b010, 1, 1, 4'b0000, 0, 1);
        case_one("R8 bc short reduced", 3'b010, 1, 0, 4'b0000, 1, 1);
    endtask

    task automatic t_pulse_len();
        settle();
        frame_bcast = 0; listen_all = 0; set_cfg(4'b0010);
        strike(3'b100);
        check("R9 pull starts", 32'(line_pull), 32'd1);
        repeat (5) @(negedge clk);
        check("R9 held w/o ticks", 32'(line_pull), 32'd1);
        tick_once();
        check("R9 after tick 1", 32'(line_pull), 32'd1);
        tick_once();
        check("R9 after tick 2", 32'(line_pull), 32'd1);
        tick_once();
        check("R9 after tick 3", 32'(line_pull), 32'd0);
    endtask

    task automatic t_no_restart();
        settle();
        frame_bcast = 0; listen_all = 0; set_cfg(4'b0010);
        strike(3'b100);
        tick_once();
        strike(3'b010);
        check("R10 flag from 2nd fault", 32'(err_flags), 32'b110);
        tick_once();
        check("R10 still pulling", 32'(line_pull), 32'd1);
        tick_once();
        check("R10 not lengthened", 32'(line_pull), 32'd0);
    endtask

    task automatic t_flags();
        settle();
        set_cfg(4'b0000); frame_bcast = 0;
        strike(3'b001);
        check("R11 rise flag bit0", 32'(err_flags), 32'b001);
        @(negedge clk) flag_clr = 3'b010;
        @(negedge clk) flag_clr = 3'b000;
        check("R11 other clear ignored", 32'(err_flags), 32'b001);
        @(negedge clk) begin flag_clr = 3'b001; fault_rise = 1'b1; end
        @(negedge clk) begin flag_clr = 3'b000; fault_rise = 1'b0; end
        check("R11 set wins over clear", 32'(err_flags), 32'b001);
        @(negedge clk) flag_clr = 3'b001;
        @(negedge clk) flag_clr = 3'b000;
        check("R11 cleared", 32'(err_flags), 32'b000);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        half_bit_tick = 0; fault_rise = 0; fault_short = 0; fault_long = 0;
        frame_bcast = 0; listen_all = 0; flag_clr = 3'b000;
        set_cfg(4'b0000);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_directed();
        t_broadcast();
        t_pulse_len();
        t_no_restart();
        t_flags();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule